// File: doc/BRIEF.md
# Window Pixel Write Engine

This block takes a rectangular window, given as first and last X/Y coordinates, together with a pixel format code and a source selector. When a transfer is set up, it checks that the window is legal. It then derives the window width and height and the number of bytes it expects to receive. After that it accepts bytes through a byte port. Each byte is passed on with its byte index inside the window. When the remaining count reaches zero, the block issues a commit pulse.

On commit, the block grows a dirty bounding box so that it covers every window committed since the last display refresh. A refresh acknowledge empties the box again. The surrounding display path reads the window geometry, the rotation code and the dirty box from the outputs. It writes the bytes it receives into its own frame store. Pixel conversion, rotation and the frame store itself sit outside this block.

A transfer starts in one of two ways: by an explicit start strobe, or by a byte write that arrives while no transfer is open. In the second case the setup uses the configuration inputs present in that cycle.

Top module: `win_blit_engine`

## Requirements
- R1: After reset, `bytes_left` is 0, `busy`, `commit` and `px_we` are 0, and the dirty box is empty. Empty means both minima are all ones (2047 at the default size) and both maxima are 0.
- R2: The bytes per pixel come from the 4-bit `fmt_code`. Code 0 gives 2 bytes, codes 1 and 2 give 3 bytes, and codes 4 and 5 give 4 bytes. Every other code gives 0 bytes, which makes the code illegal.
- R3: A setup is rejected when `src_sel` is greater than 3, when the format gives 0 bytes per pixel, when `x_last < x_first`, or when `y_last < y_first`. A rejected start leaves `bytes_left` and the geometry outputs unchanged.
- R4: A start strobe with a legal window loads the outputs in the next cycle. `win_x` and `win_y` take the first coordinates. `win_w` is `x_last - x_first + 1` and `win_h` is `y_last - y_first + 1`. `win_rot` takes `fx_sel` (2 bits). `bytes_left` is bytes-per-pixel × width × height.
- R5: A byte write while `bytes_left` is nonzero lowers `bytes_left` by one. In the next cycle it raises `px_we` for one cycle, with `px_byte` equal to the written byte and `px_idx` counting up from 0 within the transfer.
- R6: A byte write while `bytes_left` is 0 first sets up a transfer from the present inputs. If that setup is legal, the byte is taken as index 0 and `bytes_left` becomes the total minus one. If it is illegal, the byte is dropped and `px_we` stays low.
- R7: `commit` is high for exactly one cycle: the cycle after the final byte of a transfer is accepted.
- R8: The dirty box changes when `commit` rises. Its minima are lowered to `win_x`/`win_y`, and its maxima are raised to `win_x + win_w` and `win_y + win_h`.
- R9: `refresh_ack` empties the dirty box in the next cycle. If it comes in the same cycle as a final byte, the box becomes exactly the committed window.
- R10: A start strobe takes priority over a byte write in the same cycle, and that byte is dropped. A legal start during an open transfer abandons it and restarts the count and the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Set up a transfer from the configuration inputs |
| src_sel | input | 3 | Source selector, legal values 0 to 3 |
| fmt_code | input | 4 | Pixel format code |
| fx_sel | input | 2 | Rotation code captured at setup |
| x_first | input | COORD_W | Window first column |
| y_first | input | COORD_W | Window first row |
| x_last | input | COORD_W | Window last column |
| y_last | input | COORD_W | Window last row |
| data_we | input | 1 | Byte write strobe |
| data_in | input | DATA_W | Byte written |
| refresh_ack | input | 1 | Display refreshed; empty the dirty box |
| busy | output | 1 | A transfer is open |
| bytes_left | output | LEN_W | Bytes still expected |
| win_x | output | COORD_W | Captured window column |
| win_y | output | COORD_W | Captured window row |
| win_w | output | COORD_W+1 | Window width |
| win_h | output | COORD_W+1 | Window height |
| win_rot | output | 2 | Captured rotation code |
| commit | output | 1 | One-cycle window commit pulse |
| px_we | output | 1 | Accepted byte valid |
| px_byte | output | DATA_W | Accepted byte |
| px_idx | output | LEN_W | Byte index within the window |
| dirty_min_x | output | COORD_W+1 | Dirty box left edge |
| dirty_min_y | output | COORD_W+1 | Dirty box top edge |
| dirty_max_x | output | COORD_W+1 | Dirty box right edge (exclusive) |
| dirty_max_y | output | COORD_W+1 | Dirty box bottom edge (exclusive) |

## Verification
The hard collision is a refresh acknowledge that lands in the same cycle as the last byte of a window. That cycle both empties and grows the dirty box. The bench provokes it by raising `refresh_ack` together with the final `data_we`, after earlier windows have already widened the box. It passes only if the box comes out equal to the just-committed window. A second collision is a start strobe that coincides with a byte write. There the bench expects a fresh count and no byte on the output.

// File: rtl/wbe_pkg.sv
package wbe_pkg;

    localparam int FMT_W = 4;
    localparam int BPP_W = 3;

    localparam logic [FMT_W-1:0] FMT_RGB16      = 4'h0;
    localparam logic [FMT_W-1:0] FMT_RGB18_PACK = 4'h1;
    localparam logic [FMT_W-1:0] FMT_RGB24_PACK = 4'h2;
    localparam logic [FMT_W-1:0] FMT_RGB18_WORD = 4'h4;
    localparam logic [FMT_W-1:0] FMT_RGB24_WORD = 4'h5;

    // Bytes per pixel for a format code; zero marks an unusable code.
    function automatic logic [BPP_W-1:0] bpp_of(input logic [FMT_W-1:0] code);
        logic [BPP_W-1:0] r;
        unique case (code)
            FMT_RGB16:                      r = 3'd2;
            FMT_RGB18_PACK, FMT_RGB24_PACK: r = 3'd3;
            FMT_RGB18_WORD, FMT_RGB24_WORD: r = 3'd4;
            default:                        r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wbe_setup_calc.sv
module wbe_setup_calc
    import wbe_pkg::*;
#(
    parameter int COORD_W  = 10,
    parameter int SRC_W    = 3,
    parameter int SRC_LAST = 3,
    localparam int EXT_W   = COORD_W + 1,
    localparam int LEN_W   = 2 * EXT_W + BPP_W
) (
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y1,
    input  logic [FMT_W-1:0]   fmt,
    input  logic [SRC_W-1:0]   src,
    output logic               ok,
    output logic [EXT_W-1:0]   w,
    output logic [EXT_W-1:0]   h,
    output logic [LEN_W-1:0]   len
);
    logic [BPP_W-1:0] bpp;

    always_comb begin
        bpp = bpp_of(fmt);
        w   = {1'b0, x1} - {1'b0, x0} + EXT_W'(1);
        h   = {1'b0, y1} - {1'b0, y0} + EXT_W'(1);
        len = LEN_W'(bpp) * LEN_W'(w) * LEN_W'(h);
        ok  = (32'(src) <= SRC_LAST) && (bpp != '0) && (x1 >= x0) && (y1 >= y0);
    end
endmodule

// File: rtl/wbe_dirty_box.sv
module wbe_dirty_box #(
    parameter int EXT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             merge,
    input  logic [EXT_W-1:0] lo_x,
    input  logic [EXT_W-1:0] lo_y,
    input  logic [EXT_W-1:0] hi_x,
    input  logic [EXT_W-1:0] hi_y,
    output logic [EXT_W-1:0] min_x,
    output logic [EXT_W-1:0] min_y,
    output logic [EXT_W-1:0] max_x,
    output logic [EXT_W-1:0] max_y
);
    typedef struct packed {
        logic [EXT_W-1:0] min_x;
        logic [EXT_W-1:0] min_y;
        logic [EXT_W-1:0] max_x;
        logic [EXT_W-1:0] max_y;
    } box_t;

    localparam box_t EMPTY = '{min_x: '1, min_y: '1, max_x: '0, max_y: '0};

    box_t box_d, box_q;

    always_comb begin
        box_d = box_q;
        // Clear first, so a same-cycle merge leaves exactly the new window.
        if (clear) box_d = EMPTY;
        if (merge) begin
            if (lo_x < box_d.min_x) box_d.min_x = lo_x;
            if (lo_y < box_d.min_y) box_d.min_y = lo_y;
            if (hi_x > box_d.max_x) box_d.max_x = hi_x;
            if (hi_y > box_d.max_y) box_d.max_y = hi_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) box_q <= EMPTY;
        else        box_q <= box_d;
    end

    assign min_x = box_q.min_x;
    assign min_y = box_q.min_y;
    assign max_x = box_q.max_x;
    assign max_y = box_q.max_y;
endmodule

// File: rtl/win_blit_engine.sv
module win_blit_engine
    import wbe_pkg::*;
#(
    parameter int COORD_W  = 10,
    parameter int DATA_W   = 8,
    parameter int SRC_W    = 3,
    parameter int SRC_LAST = 3,
    localparam int EXT_W   = COORD_W + 1,
    localparam int LEN_W   = 2 * EXT_W + BPP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [FMT_W-1:0]   fmt_code,
    input  logic [1:0]         fx_sel,
    input  logic [COORD_W-1:0] x_first,
    input  logic [COORD_W-1:0] y_first,
    input  logic [COORD_W-1:0] x_last,
    input  logic [COORD_W-1:0] y_last,
    input  logic               data_we,
    input  logic [DATA_W-1:0]  data_in,
    input  logic               refresh_ack,
    output logic               busy,
    output logic [LEN_W-1:0]   bytes_left,
    output logic [COORD_W-1:0] win_x,
    output logic [COORD_W-1:0] win_y,
    output logic [EXT_W-1:0]   win_w,
    output logic [EXT_W-1:0]   win_h,
    output logic [1:0]         win_rot,
    output logic               commit,
    output logic               px_we,
    output logic [DATA_W-1:0]  px_byte,
    output logic [LEN_W-1:0]   px_idx,
    output logic [EXT_W-1:0]   dirty_min_x,
    output logic [EXT_W-1:0]   dirty_min_y,
    output logic [EXT_W-1:0]   dirty_max_x,
    output logic [EXT_W-1:0]   dirty_max_y
);
    typedef struct packed {
        logic [LEN_W-1:0]   left;
        logic [LEN_W-1:0]   idx;
        logic [COORD_W-1:0] wx;
        logic [COORD_W-1:0] wy;
        logic [EXT_W-1:0]   ww;
        logic [EXT_W-1:0]   wh;
        logic [1:0]         rot;
        logic               commit;
        logic               px_we;
        logic [DATA_W-1:0]  px_byte;
        logic [LEN_W-1:0]   px_idx;
    } xfer_t;

    xfer_t st_d, st_q;

    logic             cfg_ok;
    logic [EXT_W-1:0] cfg_w, cfg_h;
    logic [LEN_W-1:0] cfg_len;

    logic             load, consume, merge;
    logic [LEN_W-1:0] left_now, idx_now;
    logic [EXT_W-1:0] m_lo_x, m_lo_y, m_hi_x, m_hi_y;

    wbe_setup_calc #(
        .COORD_W (COORD_W),
        .SRC_W   (SRC_W),
        .SRC_LAST(SRC_LAST)
    ) calc_i (
        .x0 (x_first),
        .y0 (y_first),
        .x1 (x_last),
        .y1 (y_last),
        .fmt(fmt_code),
        .src(src_sel),
        .ok (cfg_ok),
        .w  (cfg_w),
        .h  (cfg_h),
        .len(cfg_len)
    );

    always_comb begin
        st_d         = st_q;
        st_d.commit  = 1'b0;
        st_d.px_we   = 1'b0;
        load         = 1'b0;
        consume      = 1'b0;
        merge        = 1'b0;

        // Start wins over a byte write in the same cycle; that byte is lost.
        if (start) begin
            load = cfg_ok;
        end else if (data_we) begin
            if (st_q.left != '0) begin
                consume = 1'b1;
            end else if (cfg_ok) begin
                load    = 1'b1;
                consume = 1'b1;
            end
        end

        left_now = load ? cfg_len : st_q.left;
        idx_now  = load ? '0      : st_q.idx;

        if (load) begin
            st_d.wx  = x_first;
            st_d.wy  = y_first;
            st_d.ww  = cfg_w;
            st_d.wh  = cfg_h;
            st_d.rot = fx_sel;
        end
        st_d.left = left_now;
        st_d.idx  = idx_now;

        if (consume) begin
            st_d.px_we   = 1'b1;
            st_d.px_byte = data_in;
            st_d.px_idx  = idx_now;
            st_d.idx     = idx_now + LEN_W'(1);
            st_d.left    = left_now - LEN_W'(1);
            if (left_now == LEN_W'(1)) begin
                st_d.commit = 1'b1;
                merge       = 1'b1;
            end
        end

        m_lo_x = {1'b0, st_d.wx};
        m_lo_y = {1'b0, st_d.wy};
        m_hi_x = m_lo_x + st_d.ww;
        m_hi_y = m_lo_y + st_d.wh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wbe_dirty_box #(.EXT_W(EXT_W)) box_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(refresh_ack),
        .merge(merge),
        .lo_x (m_lo_x),
        .lo_y (m_lo_y),
        .hi_x (m_hi_x),
        .hi_y (m_hi_y),
        .min_x(dirty_min_x),
        .min_y(dirty_min_y),
        .max_x(dirty_max_x),
        .max_y(dirty_max_y)
    );

    assign busy       = (st_q.left != '0);
    assign bytes_left = st_q.left;
    assign win_x      = st_q.wx;
    assign win_y      = st_q.wy;
    assign win_w      = st_q.ww;
    assign win_h      = st_q.wh;
    assign win_rot    = st_q.rot;
    assign commit     = st_q.commit;
    assign px_we      = st_q.px_we;
    assign px_byte    = st_q.px_byte;
    assign px_idx     = st_q.px_idx;
endmodule

// File: rtl/wbe_checker.sv
module wbe_checker #(
    parameter int COORD_W  = 10,
    parameter int SRC_W    = 3,
    parameter int SRC_LAST = 3,
    parameter int LEN_W    = 25,
    localparam int EXT_W   = COORD_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [SRC_W-1:0]   src_sel,
    input logic               data_we,
    input logic               refresh_ack,
    input logic [LEN_W-1:0]   bytes_left,
    input logic [COORD_W-1:0] win_x,
    input logic [COORD_W-1:0] win_y,
    input logic [EXT_W-1:0]   win_w,
    input logic [EXT_W-1:0]   win_h,
    input logic               commit,
    input logic               px_we,
    input logic [EXT_W-1:0]   dirty_min_x,
    input logic [EXT_W-1:0]   dirty_min_y,
    input logic [EXT_W-1:0]   dirty_max_x,
    input logic [EXT_W-1:0]   dirty_max_y
);
    logic [EXT_W-1:0] ex_x, ex_y;
    assign ex_x = {1'b0, win_x};
    assign ex_y = {1'b0, win_y};

    // R7
    commit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R7
    commit_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(data_we) && !$past(start)
                    && $past(bytes_left) == LEN_W'(1) && bytes_left == '0));

    // R5
    byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !start && bytes_left != '0)
        |=> (px_we && bytes_left == $past(bytes_left) - LEN_W'(1)));

    // R8
    box_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (dirty_min_x <= ex_x && dirty_min_y <= ex_y
                    && dirty_max_x >= ex_x + win_w && dirty_max_y >= ex_y + win_h));

    // R9
    box_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_ack && !(data_we && !start && bytes_left == LEN_W'(1)))
        |=> (dirty_min_x == '1 && dirty_min_y == '1
             && dirty_max_x == '0 && dirty_max_y == '0));

    // R10
    start_drops_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !px_we);

    // R3
    bad_source_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && 32'(src_sel) > SRC_LAST)
        |=> ($stable(bytes_left) && $stable(win_w) && $stable(win_h)));
endmodule

bind win_blit_engine wbe_checker #(
    .COORD_W (COORD_W),
    .SRC_W   (SRC_W),
    .SRC_LAST(SRC_LAST),
    .LEN_W   (LEN_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .src_sel    (src_sel),
    .data_we    (data_we),
    .refresh_ack(refresh_ack),
    .bytes_left (bytes_left),
    .win_x      (win_x),
    .win_y      (win_y),
    .win_w      (win_w),
    .win_h      (win_h),
    .commit     (commit),
    .px_we      (px_we),
    .dirty_min_x(dirty_min_x),
    .dirty_min_y(dirty_min_y),
    .dirty_max_x(dirty_max_x),
    .dirty_max_y(dirty_max_y)
);

// File: tb/win_blit_engine_tb_top.sv
module win_blit_engine_tb_top;
    localparam int CW = 10;
    localparam int EW = CW + 1;
    localparam int LW = 2 * EW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    src_sel = '0;
    logic [3:0]    fmt_code = '0;
    logic [1:0]    fx_sel = '0;
    logic [CW-1:0] x_first = '0, y_first = '0, x_last = '0, y_last = '0;
    logic          data_we = 1'b0;
    logic [7:0]    data_in = '0;
    logic          refresh_ack = 1'b0;
    logic          busy, commit, px_we;
    logic [LW-1:0] bytes_left, px_idx;
    logic [CW-1:0] win_x, win_y;
    logic [EW-1:0] win_w, win_h;
    logic [1:0]    win_rot;
    logic [7:0]    px_byte;
    logic [EW-1:0] dirty_min_x, dirty_min_y, dirty_max_x, dirty_max_y;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0]    b;
        logic [LW-1:0] i;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    win_blit_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .fmt_code(fmt_code), .fx_sel(fx_sel),
        .x_first(x_first), .y_first(y_first), .x_last(x_last), .y_last(y_last),
        .data_we(data_we), .data_in(data_in), .refresh_ack(refresh_ack),
        .busy(busy), .bytes_left(bytes_left), .win_x(win_x), .win_y(win_y),
        .win_w(win_w), .win_h(win_h), .win_rot(win_rot), .commit(commit),
        .px_we(px_we), .px_byte(px_byte), .px_idx(px_idx),
        .dirty_min_x(dirty_min_x), .dirty_min_y(dirty_min_y),
        .dirty_max_x(dirty_max_x), .dirty_max_y(dirty_max_y)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every accepted byte must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && px_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5/R6/R10 unexpected byte: actual %0d idx %0d expected none",
                         px_byte, px_idx);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (px_byte != e.b || px_idx != e.i) begin
                    errors++;
                    $display("FAIL R5 byte/idx: actual %0d/%0d expected %0d/%0d",
                             px_byte, px_idx, e.b, e.i);
                end
            end
        end
    end

    task automatic set_win(input int x0, input int y0, input int x1, input int y1,
                           input int fmt, input int src, input int rot);
        x_first = CW'(x0); y_first = CW'(y0); x_last = CW'(x1); y_last = CW'(y1);
        fmt_code = 4'(fmt); src_sel = 3'(src); fx_sel = 2'(rot);
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic put(input int b, input bit accept, input int idx);
        data_we = 1'b1;
        data_in = 8'(b);
        if (accept) exp_q.push_back('{b: 8'(b), i: LW'(idx)});
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic chk_box(input string req, input int x0, input int y0,
                           input int x1, input int y1);
        chk({req, " min_x"}, dirty_min_x, x0);
        chk({req, " min_y"}, dirty_min_y, y0);
        chk({req, " max_x"}, dirty_max_x, x1);
        chk({req, " max_y"}, dirty_max_y, y1);
    endtask

    function automatic int exp_bpp(input int code);
        case (code)
            0:       return 2;
            1, 2:    return 3;
            4, 5:    return 4;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 bytes_left", bytes_left, 0);
        chk("R1 busy", busy, 0);
        chk("R1 commit", commit, 0);
        chk("R1 px_we", px_we, 0);
        chk_box("R1", 2047, 2047, 0, 0);

        // R3 rejections
        set_win(5, 3, 6, 3, 2, 4, 0); do_start();
        chk("R3 src>3 bytes_left", bytes_left, 0);
        chk("R3 src>3 win_w", win_w, 0);
        set_win(5, 3, 6, 3, 3, 0, 0); do_start();
        chk("R3 bpp0 bytes_left", bytes_left, 0);
        set_win(5, 3, 4, 3, 2, 0, 0); do_start();
        chk("R3 x_last<x_first bytes_left", bytes_left, 0);
        set_win(5, 3, 6, 2, 2, 0, 0); do_start();
        chk("R3 y_last<y_first bytes_left", bytes_left, 0);
        // R6 write with an illegal setup is dropped
        put(8'hAA, 1'b0, 0);
        chk("R6 dropped px_we", px_we, 0);
        chk("R6 dropped bytes_left", bytes_left, 0);

        // R4 legal setup: 2x1 window, 3 bytes per pixel
        set_win(5, 3, 6, 3, 2, 0, 2); do_start();
        chk("R4 win_x", win_x, 5);
        chk("R4 win_y", win_y, 3);
        chk("R4 win_w", win_w, 2);
        chk("R4 win_h", win_h, 1);
        chk("R4 win_rot", win_rot, 2);
        chk("R4 bytes_left", bytes_left, 6);
        chk("R4 busy", busy, 1);

        // R5 stream of bytes, R7 commit, R8 box
        for (int k = 0; k < 5; k++) put(8'h10 + k, 1'b1, k);
        chk("R5 bytes_left", bytes_left, 1);
        chk("R7 no early commit", commit, 0);
        put(8'h15, 1'b1, 5);
        chk("R7 commit", commit, 1);
        chk("R5 bytes_left end", bytes_left, 0);
        chk_box("R8 first", 5, 3, 7, 4);
        @(negedge clk);
        chk("R7 commit one cycle", commit, 0);

        // R6 implicit setup by a byte write: 1x2 window, 2 bytes per pixel
        set_win(2, 10, 2, 11, 0, 0, 1);
        put(8'h20, 1'b1, 0);
        chk("R6 bytes_left", bytes_left, 3);
        chk("R6 win_y", win_y, 10);
        chk("R6 win_h", win_h, 2);
        chk("R6 win_rot", win_rot, 1);
        for (int k = 1; k < 4; k++) put(8'h20 + k, 1'b1, k);
        chk("R7 commit second", commit, 1);
        chk_box("R8 grow", 2, 3, 7, 12);

        // R9 refresh alone
        refresh_ack = 1'b1; @(negedge clk); refresh_ack = 1'b0;
        chk_box("R9 clear", 2047, 2047, 0, 0);
        set_win(6, 6, 6, 6, 0, 0, 0); do_start();
        put(8'h31, 1'b1, 0); put(8'h32, 1'b1, 1);
        chk_box("R8 after clear", 6, 6, 7, 7);

        // R9 refresh in the same cycle as a final byte
        set_win(0, 0, 0, 0, 5, 0, 0); do_start();
        for (int k = 0; k < 3; k++) put(8'h40 + k, 1'b1, k);
        refresh_ack = 1'b1;
        put(8'h43, 1'b1, 3);
        refresh_ack = 1'b0;
        chk("R9 commit with refresh", commit, 1);
        chk_box("R9 collide", 0, 0, 1, 1);

        // R10 start with a byte write in the same cycle: byte dropped
        set_win(4, 4, 5, 5, 1, 0, 3);
        data_we = 1'b1; data_in = 8'h77;
        do_start();
        data_we = 1'b0;
        chk("R10 bytes_left", bytes_left, 12);
        chk("R10 px_we", px_we, 0);
        put(8'h50, 1'b1, 0); put(8'h51, 1'b1, 1);
        // R10 restart during an open transfer
        set_win(8, 8, 8, 8, 2, 0, 0); do_start();
        chk("R10 restart bytes_left", bytes_left, 3);
        for (int k = 0; k < 3; k++) put(8'h60 + k, 1'b1, k);
        chk("R7 commit restart", commit, 1);
        chk_box("R8 restart", 0, 0, 9, 9);

        // R2 format table through a 1x1 window
        begin
            int prev;
            prev = int'(bytes_left);
            for (int code = 0; code < 16; code++) begin
                int e;
                set_win(0, 0, 0, 0, code, 0, 0); do_start();
                e = (exp_bpp(code) != 0) ? exp_bpp(code) : prev;
                chk($sformatf("R2 code %0d", code), bytes_left, e);
                prev = e;
            end
        end

        @(negedge clk);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule